// File: doc/BRIEF.md
# Lookahead-Gated Multithread Issue Scheduler

This block picks which hardware thread launches an instruction in each clock cycle. It picks at most one thread per cycle from a pool of threads. Every thread presents an instruction-ready flag, a 3-bit lookahead count and a memory/non-memory flag for the instruction at its head. The lookahead count states how many of the instructions that follow do not depend on that instruction. The block keeps one tracked "anchor" operation per thread. When a thread with no tracked operation issues, that instruction becomes its anchor, and its lookahead becomes a credit budget. While the anchor is unresolved, each later issue from the thread uses up one credit. When no credit is left, the thread waits until the anchor resolves.

A non-memory anchor resolves after a fixed pipeline latency, counted per thread. A memory anchor resolves only when the thread's completion strobe arrives. Among the threads that may issue, the grant rotates round-robin, starting after the thread that issued last. The issue decision is combinational on registered per-thread state. A surrounding fetch or decode stage therefore sees the granted thread in the same cycle that it presents its head instructions.

Top module: `issue_la_sched`

## Requirements
- R1: While rst_n is low, issue_valid is 0 even when every thread has an instruction available. In the first cycle after release, the grant goes to the lowest-numbered available thread.
- R2: At most one thread is issued per cycle, and only a thread whose inst_avail bit is 1. When inst_avail is all zero, issue_valid is 0.
- R3: Thread t's lookahead is inst_lookahead[3*t+2:3*t], an unsigned value from 0 to 7. A thread with no tracked operation that issues with lookahead L may issue exactly L further instructions before it blocks, provided its anchor has not resolved in the meantime.
- R4: A non-memory anchor (inst_is_mem[t]=0 at its issue) that issues in cycle c leaves the thread blocked, if it has no credit, until cycle c+PIPE_LAT. In that cycle the thread may issue again. PIPE_LAT defaults to 21.
- R5: A memory anchor (inst_is_mem[t]=1 at its issue) keeps the thread blocked, once its credit is used up, for as long as mem_done[t] stays low, whatever the elapsed time. A one-cycle pulse of mem_done[t] in cycle d lets the thread issue in cycle d+1.
- R6: mem_done[t] has no effect on thread t while the thread is not waiting on a memory anchor. This includes the time a non-memory anchor is timing out.
- R7: Grants rotate round-robin. The search starts at the thread after the most recently issued one, in increasing index order, and wraps from the highest thread to thread 0.
- R8: If any thread is eligible (available, and either free of a tracked operation or holding credit), issue_valid is 1 in that cycle.
- R9: If a thread issues in the same cycle that its anchor resolves, the issued instruction becomes the new anchor. Its own lookahead and memory flag take effect, and the timing restarts from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_avail | input | N_THREADS | Per-thread flag: a head instruction is ready |
| inst_lookahead | input | N_THREADS*LA_W | Per-thread lookahead count of the head instruction, 3 bits per thread |
| inst_is_mem | input | N_THREADS | Per-thread flag: the head instruction is a memory operation |
| mem_done | input | N_THREADS | Per-thread memory completion strobe |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_tid | output | TID_W | Index of the issued thread |

## Verification
The bench builds the block with its defaults: 16 threads, a 3-bit lookahead and a 21-cycle pipeline latency. With these values the full credit range 0 to 7 and the exact 21-cycle reopening point can be checked cycle by cycle. The round-robin wrap from thread 15 back to thread 0 is also in reach. A memory wait that lasts well past the pipeline latency shows that only the strobe releases a memory anchor. Sparse thread sets show that empty slots in the rotation are skipped without bubbles.

// File: rtl/issue_pkg.sv
package issue_pkg;

   // Tracking state of the oldest unresolved operation of one thread.
   typedef enum logic [1:0] {
      CTX_FREE    = 2'd0,   // no tracked operation
      CTX_TIMED   = 2'd1,   // non-memory anchor, waiting out the pipeline
      CTX_MEMWAIT = 2'd2    // memory anchor, waiting for its strobe
   } ctx_mode_e;

   // Smallest legal pipeline latency: the countdown needs one live cycle.
   localparam int unsigned MIN_PIPE_LAT = 2;

endpackage

// File: rtl/issue_thread_ctx.sv
module issue_thread_ctx
   import issue_pkg::*;
#(
   parameter int unsigned LA_W     = 3,
   parameter int unsigned PIPE_LAT = 21
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            avail,
   input  logic [LA_W-1:0] lookahead,
   input  logic            is_mem,
   input  logic            mem_done,
   input  logic            grant,
   output logic            eligible,
   output logic            pending
);

   localparam int unsigned TMR_W = $clog2(PIPE_LAT);
   localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PIPE_LAT - 1);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(1);

   ctx_mode_e         mode_q;
   logic [LA_W-1:0]   credit_q;
   logic [TMR_W-1:0]  timer_q;
   logic              resolve;
   logic              start_anchor;

   // The anchor resolves on the last countdown cycle or on its memory strobe.
   always_comb begin
      unique case (mode_q)
         CTX_TIMED:   resolve = (timer_q == TMR_LAST);
         CTX_MEMWAIT: resolve = mem_done;
         default:     resolve = 1'b0;
      endcase
   end

   assign pending      = (mode_q != CTX_FREE);
   assign eligible     = avail & (!pending | (credit_q != '0));
   assign start_anchor = !pending | resolve;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= CTX_FREE;
         credit_q <= '0;
         timer_q  <= '0;
      end else if (grant) begin
         if (start_anchor) begin
            mode_q   <= is_mem ? CTX_MEMWAIT : CTX_TIMED;
            credit_q <= lookahead;
            timer_q  <= TMR_LOAD;
         end else begin
            credit_q <= credit_q - 1'b1;
            if (mode_q == CTX_TIMED) begin
               timer_q <= timer_q - 1'b1;
            end
         end
      end else if (resolve) begin
         mode_q <= CTX_FREE;
      end else if (mode_q == CTX_TIMED) begin
         timer_q <= timer_q - 1'b1;
      end
   end

endmodule

// File: rtl/issue_rr_arb.sv
module issue_rr_arb #(
   parameter int unsigned N_REQ = 16,
   parameter int unsigned ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic             advance,
   output logic [N_REQ-1:0] gnt,
   output logic [ID_W-1:0]  gnt_id,
   output logic             any
);

   localparam logic [ID_W-1:0] LAST_INIT = ID_W'(N_REQ - 1);

   logic [ID_W-1:0]  last_q;
   logic [N_REQ-1:0] above_mask;
   logic [N_REQ-1:0] req_hi;
   logic [ID_W-1:0]  pick_hi;
   logic [ID_W-1:0]  pick_all;

   // Threads strictly after the last issued one form the first search window.
   for (genvar gi = 0; gi < N_REQ; gi++) begin : g_mask
      assign above_mask[gi] = (gi > int'(last_q));
   end

   assign req_hi = req & above_mask;

   always_comb begin
      pick_hi  = '0;
      pick_all = '0;
      for (int i = N_REQ - 1; i >= 0; i--) begin
         if (req_hi[i]) pick_hi = ID_W'(i);
         if (req[i])    pick_all = ID_W'(i);
      end
   end

   assign any    = |req;
   assign gnt_id = (|req_hi) ? pick_hi : pick_all;

   for (genvar gi = 0; gi < N_REQ; gi++) begin : g_onehot
      assign gnt[gi] = any & (gnt_id == ID_W'(gi));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= LAST_INIT;
      end else if (advance) begin
         last_q <= gnt_id;
      end
   end

endmodule

// File: rtl/issue_la_sched.sv
module issue_la_sched #(
   parameter int unsigned N_THREADS = 16,
   parameter int unsigned LA_W      = 3,
   parameter int unsigned PIPE_LAT  = 21,
   localparam int unsigned TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_THREADS-1:0]      inst_avail,
   input  logic [N_THREADS*LA_W-1:0] inst_lookahead,
   input  logic [N_THREADS-1:0]      inst_is_mem,
   input  logic [N_THREADS-1:0]      mem_done,
   output logic                      issue_valid,
   output logic [TID_W-1:0]          issue_tid
);

   if (PIPE_LAT < issue_pkg::MIN_PIPE_LAT) begin : g_bad_lat
      $error("issue_la_sched: PIPE_LAT must be at least 2");
   end
   if (N_THREADS < 2) begin : g_bad_thr
      $error("issue_la_sched: N_THREADS must be at least 2");
   end
   if (LA_W < 1) begin : g_bad_la
      $error("issue_la_sched: LA_W must be at least 1");
   end

   logic [N_THREADS-1:0] elig_vec;
   logic [N_THREADS-1:0] pend_vec;
   logic [N_THREADS-1:0] arb_gnt;
   logic [N_THREADS-1:0] grant_vec;
   logic [TID_W-1:0]     arb_id;
   logic                 arb_any;

   for (genvar gt = 0; gt < N_THREADS; gt++) begin : g_thread
      issue_thread_ctx #(
         .LA_W     (LA_W),
         .PIPE_LAT (PIPE_LAT)
      ) ctx_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .avail     (inst_avail[gt]),
         .lookahead (inst_lookahead[gt*LA_W +: LA_W]),
         .is_mem    (inst_is_mem[gt]),
         .mem_done  (mem_done[gt]),
         .grant     (grant_vec[gt]),
         .eligible  (elig_vec[gt]),
         .pending   (pend_vec[gt])
      );
   end

   issue_rr_arb #(
      .N_REQ (N_THREADS),
      .ID_W  (TID_W)
   ) arb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (elig_vec),
      .advance (issue_valid),
      .gnt     (arb_gnt),
      .gnt_id  (arb_id),
      .any     (arb_any)
   );

   assign grant_vec   = arb_gnt & {N_THREADS{rst_n}};
   assign issue_valid = arb_any & rst_n;
   assign issue_tid   = arb_id;

endmodule

// File: rtl/issue_la_sched_chk.sv
module issue_la_sched_chk #(
   parameter int unsigned N_THREADS = 16,
   parameter int unsigned LA_W      = 3,
   parameter int unsigned TID_W     = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [N_THREADS-1:0]      inst_avail,
   input logic [N_THREADS*LA_W-1:0] inst_lookahead,
   input logic                      issue_valid,
   input logic [TID_W-1:0]          issue_tid,
   input logic [N_THREADS-1:0]      elig_vec,
   input logic [N_THREADS-1:0]      grant_vec,
   input logic [N_THREADS-1:0]      pend_vec
);

   // R2
   avail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> inst_avail[issue_tid]);

   // R2
   idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_avail == '0) |-> !issue_valid);

   // R2
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec) && (issue_valid == (grant_vec != '0)));

   // R8
   work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elig_vec != '0) |-> issue_valid);

   // R3
   zero_credit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !pend_vec[issue_tid]
       && (inst_lookahead[issue_tid*LA_W +: LA_W] == '0))
      |=> !(issue_valid && (issue_tid == $past(issue_tid))));

endmodule

bind issue_la_sched issue_la_sched_chk #(
   .N_THREADS (N_THREADS),
   .LA_W      (LA_W),
   .TID_W     (TID_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .inst_avail     (inst_avail),
   .inst_lookahead (inst_lookahead),
   .issue_valid    (issue_valid),
   .issue_tid      (issue_tid),
   .elig_vec       (elig_vec),
   .grant_vec      (grant_vec),
   .pend_vec       (pend_vec)
);

// File: tb/issue_la_sched_tb_top.sv
`timescale 1ns/1ps
module issue_la_sched_tb_top;

   localparam int NT  = 16;
   localparam int LW  = 3;
   localparam int LAT = 21;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NT-1:0]   inst_avail = '0;
   logic [NT*LW-1:0] inst_lookahead = '0;
   logic [NT-1:0]   inst_is_mem = '0;
   logic [NT-1:0]   mem_done = '0;
   logic            issue_valid;
   logic [3:0]      issue_tid;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   issue_la_sched #(.N_THREADS(NT), .LA_W(LW), .PIPE_LAT(LAT)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .inst_avail     (inst_avail),
      .inst_lookahead (inst_lookahead),
      .inst_is_mem    (inst_is_mem),
      .mem_done       (mem_done),
      .issue_valid    (issue_valid),
      .issue_tid      (issue_tid)
   );

   task automatic step(input logic ev, input int et, input string tag);
      @(negedge clk);
      checks++;
      if (issue_valid !== ev || (ev && (int'(issue_tid) != et))) begin
         errors++;
         $display("FAIL %s t=%0t: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                  tag, $time, issue_valid, issue_tid, ev, et);
      end
      @(posedge clk); #1;
   endtask

   task automatic set_t(input int t, input bit av, input int la, input bit mem);
      inst_avail[t] = av;
      inst_lookahead[t*LW +: LW] = la[LW-1:0];
      inst_is_mem[t] = mem;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      inst_avail = '0; inst_lookahead = '0; inst_is_mem = '0; mem_done = '0;
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic release_rst();
      rst_n = 1'b1;
   endtask

   // R1, R2: reset hold-off, first grant, empty input
   task automatic t_reset();
      do_reset();
      for (int t = 0; t < NT; t++) set_t(t, 1'b1, 0, 1'b0);
      step(1'b0, 0, "R1 reset hold");
      release_rst();
      step(1'b1, 0, "R1 first grant");
      step(1'b1, 1, "R7 next thread");
      inst_avail = '0;
      step(1'b0, 0, "R2 none available");
   endtask

   // R3, R4: single thread, lookahead 3, non-memory
   task automatic t_lookahead();
      do_reset();
      set_t(5, 1'b1, 3, 1'b0);
      release_rst();
      for (int k = 0; k <= 25; k++) begin
         bit ev;
         ev = (k <= 3) || (k >= LAT && k <= LAT + 3);
         step(ev, 5, (k < LAT) ? "R3 credit run" : "R4 reopen at latency");
      end
   endtask

   // R5: memory anchor waits for strobe
   task automatic t_mem_wait();
      do_reset();
      set_t(2, 1'b1, 0, 1'b1);
      release_rst();
      step(1'b1, 2, "R5 anchor");
      for (int k = 1; k <= 40; k++) step(1'b0, 2, "R5 blocked past latency");
      mem_done[2] = 1'b1;
      step(1'b0, 2, "R5 strobe cycle");
      mem_done[2] = 1'b0;
      step(1'b1, 2, "R5 issue after strobe");
      step(1'b0, 2, "R5 new anchor blocks");
   endtask

   // R6: stray strobe on a timed anchor
   task automatic t_stray_strobe();
      do_reset();
      set_t(7, 1'b1, 0, 1'b0);
      release_rst();
      step(1'b1, 7, "R6 anchor");
      for (int k = 1; k < LAT; k++) begin
         mem_done[7] = (k == 5);
         step(1'b0, 7, "R6 strobe ignored");
      end
      mem_done[7] = 1'b0;
      step(1'b1, 7, "R6 reopen at latency");
   endtask

   // R7, R8: full rotation and wrap
   task automatic t_full_rr();
      do_reset();
      for (int t = 0; t < NT; t++) set_t(t, 1'b1, 7, 1'b0);
      release_rst();
      for (int k = 0; k < 40; k++) step(1'b1, k % NT, "R7 full rotation");
   endtask

   // R7, R8: sparse set skips idle threads
   task automatic t_sparse_rr();
      do_reset();
      set_t(3, 1'b1, 7, 1'b0);
      set_t(9, 1'b1, 7, 1'b0);
      set_t(12, 1'b1, 7, 1'b0);
      release_rst();
      for (int k = 0; k < 9; k++) begin
         int e;
         e = (k % 3 == 0) ? 3 : ((k % 3 == 1) ? 9 : 12);
         step(1'b1, e, "R8 sparse rotation");
      end
   endtask

   // R4, R8: two zero-lookahead threads
   task automatic t_pair();
      do_reset();
      set_t(1, 1'b1, 0, 1'b0);
      set_t(4, 1'b1, 0, 1'b0);
      release_rst();
      step(1'b1, 1, "R8 pair first");
      step(1'b1, 4, "R8 pair second");
      for (int k = 2; k < LAT; k++) step(1'b0, 0, "R4 pair blocked");
      step(1'b1, 1, "R4 pair reopen first");
      step(1'b1, 4, "R4 pair reopen second");
   endtask

   // R9: issue in the resolve cycle re-anchors
   task automatic t_reanchor();
      do_reset();
      set_t(6, 1'b1, 2, 1'b1);
      release_rst();
      step(1'b1, 6, "R9 memory anchor");
      inst_avail[6] = 1'b0;
      for (int k = 1; k < 5; k++) step(1'b0, 6, "R2 withheld");
      set_t(6, 1'b1, 0, 1'b0);
      mem_done[6] = 1'b1;
      step(1'b1, 6, "R9 issue at resolve");
      mem_done[6] = 1'b0;
      for (int k = 6; k < 5 + LAT; k++) step(1'b0, 6, "R9 new anchor blocks");
      step(1'b1, 6, "R9 new anchor reopens");
   endtask

   initial begin
      t_reset();
      t_lookahead();
      t_mem_wait();
      t_stray_strobe();
      t_full_rr();
      t_sparse_rr();
      t_pair();
      t_reanchor();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got running, expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule